// File: doc/BRIEF.md
# Multiplexed LED Sign Scan Controller

This block refreshes a large multiplexed LED sign. The sign is built from current-sink shift-register chains that select columns, and from a set of row power phases that select rows. Two chains are loaded in lockstep. Each chain has its own serial data line, and each chain gets its own copy of the serial clock and the latch strobe. With the default settings each chain is 192 bits long and the sign has 16 row phases.

For each row phase the controller reads pixel bits from a synchronous frame-buffer read port. That port returns one bit per chain for each address and has one cycle of latency. The controller first shifts a configurable number of zero pad bits and then the pixel bits. It then blanks all rows, pulses the latch, waits out a second dead time, and finally lights the row whose data was just latched. Lighting that row also advances the phase. A one-cycle frame-start pulse marks the beginning of phase 0.

Top module: `led_scan_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sclk`, `sdata`, `latch`, `row_en` and `fb_rd_en` are all zero. The controller restarts with the load of phase 0.
- R2: The serial-clock half period is H = max(HALF_DIV, ceil(CLK_HZ / (2*MAX_SCLK_HZ))) cycles. Each bit holds `sclk` low for H cycles and then high for H cycles. `sclk` stays low outside a row load.
- R3: `sdata` changes only at the start of a bit, which is when `sclk` goes low. It is stable for the whole high half.
- R4: A row load is preceded by two setup cycles. It then shifts PAD_BITS zeros followed by CHAIN_BITS pixel bits, with data index 0 first. Chain c takes its bit from `fb_rd_data[c]`, and both chains share identical clock and latch timing.
- R5: The read address is {phase, data index}, with the phase in the upper bits. `fb_rd_en` is high for exactly one cycle per pixel bit, with the address of that bit. The returned bit appears on `sdata` at the start of that bit.
- R6: After the last bit there are DEAD_CYCLES cycles with `latch` low. `latch` is then high for LATCH_CYCLES cycles, followed by another DEAD_CYCLES cycles.
- R7: At the end of the second dead time, `row_en` becomes one-hot on the phase that was just latched (bit p for phase p). It stays on until the next row load ends. The phase then advances by one and wraps from NUM_PHASES-1 to 0.
- R8: `frame_start` is high for exactly one cycle, namely the first setup cycle of each phase-0 load.
- R9: All rows are off from the end of each row load until the second dead time has elapsed. No more than one row is ever on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_addr | output | PW+IW | Read address {phase, data index} |
| fb_rd_data | input | NUM_CHAINS | One pixel bit per chain, one cycle after the read |
| sclk | output | NUM_CHAINS | Serial clock per chain |
| sdata | output | NUM_CHAINS | Serial data per chain |
| latch | output | NUM_CHAINS | Active-high latch strobe per chain |
| row_en | output | NUM_PHASES | One-hot row power enables, active high |
| frame_start | output | 1 | One-cycle pulse at the start of phase 0 |

## Verification
A wrong bit counter or half-period count shows up at `sclk` and `sdata` within one bit time. It appears either as a bit shifted by one position or as a high phase of the wrong length. A wrong wait counter moves the `latch` edges or the `row_en` edges by whole cycles in the same row period. A wrong phase register shows up as a wrong upper field on `fb_addr` in the next load, and as a wrong lit row or a misplaced `frame_start` within one row period. Checking every cycle of a full frame plus one wrap exposes each of these within one refresh.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SHIFT,
    ST_BLANK_A,
    ST_LATCH,
    ST_BLANK_B
  } scan_state_e;

  typedef struct packed {
    logic sclk_nxt;
    logic latch_nxt;
    logic load;
    logic pad;
    logic clear;
  } lane_ctl_t;
endpackage

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int CHAIN_BITS   = 192,
  parameter int PAD_BITS     = 8,
  parameter int NUM_PHASES   = 16,
  parameter int HALF         = 16,
  parameter int DEAD_CYCLES  = 25,
  parameter int LATCH_CYCLES = 200,
  localparam int TOTAL = CHAIN_BITS + PAD_BITS,
  localparam int BW    = $clog2(TOTAL),
  localparam int CW    = $clog2(2 * HALF),
  localparam int IW    = $clog2(CHAIN_BITS),
  localparam int PW    = $clog2(NUM_PHASES),
  localparam int WMAX  = (DEAD_CYCLES > LATCH_CYCLES) ? DEAD_CYCLES : LATCH_CYCLES,
  localparam int WW    = $clog2(WMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output lane_ctl_t        ctl,
  output logic             rd_en,
  output logic [PW+IW-1:0] rd_addr,
  output logic             blank_ev,
  output logic             show_ev,
  output logic [PW-1:0]    phase,
  output logic             frame_start
);
  scan_state_e   st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] bidx_q, bidx_n;
  logic [WW-1:0] wcnt_q, wcnt_n;
  logic [PW-1:0] phase_q, phase_n;
  logic          fs_q, fs_n;
  logic          load;
  logic [BW:0]   bnext, didx;
  logic [IW-1:0] rd_idx;

  assign bnext = {1'b0, bidx_q} + (BW+1)'(1);
  assign didx  = bnext - (BW+1)'(PAD_BITS);

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    bidx_n   = bidx_q;
    wcnt_n   = wcnt_q;
    phase_n  = phase_q;
    load     = 1'b0;
    blank_ev = 1'b0;
    show_ev  = 1'b0;
    fs_n     = 1'b0;
    rd_en    = 1'b0;
    rd_idx   = '0;
    unique case (st_q)
      ST_IDLE: begin
        st_n  = ST_PRE;
        cnt_n = '0;
        fs_n  = 1'b1;
      end
      ST_PRE: begin
        if (cnt_q == '0) begin
          cnt_n = CW'(1);
          rd_en = (PAD_BITS == 0);
        end else begin
          st_n   = ST_SHIFT;
          cnt_n  = '0;
          bidx_n = '0;
          load   = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == CW'(2 * HALF - 2) && bidx_q != BW'(TOTAL - 1) &&
            int'(bnext) >= PAD_BITS) begin
          rd_en  = 1'b1;
          rd_idx = didx[IW-1:0];
        end
        if (cnt_q == CW'(2 * HALF - 1)) begin
          cnt_n = '0;
          if (bidx_q == BW'(TOTAL - 1)) begin
            st_n     = ST_BLANK_A;
            wcnt_n   = '0;
            blank_ev = 1'b1;
          end else begin
            bidx_n = bidx_q + BW'(1);
            load   = 1'b1;
          end
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      ST_BLANK_A: begin
        if (wcnt_q == WW'(DEAD_CYCLES - 1)) begin
          st_n   = ST_LATCH;
          wcnt_n = '0;
        end else begin
          wcnt_n = wcnt_q + WW'(1);
        end
      end
      ST_LATCH: begin
        if (wcnt_q == WW'(LATCH_CYCLES - 1)) begin
          st_n   = ST_BLANK_B;
          wcnt_n = '0;
        end else begin
          wcnt_n = wcnt_q + WW'(1);
        end
      end
      ST_BLANK_B: begin
        if (wcnt_q == WW'(DEAD_CYCLES - 1)) begin
          st_n    = ST_PRE;
          cnt_n   = '0;
          show_ev = 1'b1;
          fs_n    = (phase_q == PW'(NUM_PHASES - 1));
          phase_n = fs_n ? '0 : phase_q + PW'(1);
        end else begin
          wcnt_n = wcnt_q + WW'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.sclk_nxt  = (st_n == ST_SHIFT) && (int'(cnt_n) >= HALF);
    ctl.latch_nxt = (st_n == ST_LATCH);
    ctl.load      = load;
    ctl.pad       = int'(bidx_n) < PAD_BITS;
    ctl.clear     = (st_n != ST_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      wcnt_q  <= '0;
      phase_q <= '0;
      fs_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      wcnt_q  <= wcnt_n;
      phase_q <= phase_n;
      fs_q    <= fs_n;
    end
  end

  assign rd_addr     = {phase_q, rd_idx};
  assign phase       = phase_q;
  assign frame_start = fs_q;
endmodule

// File: rtl/led_scan_lane.sv
module led_scan_lane
  import led_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lane_ctl_t ctl,
  input  logic      rd_bit,
  output logic      sclk,
  output logic      sdata,
  output logic      latch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk  <= 1'b0;
      sdata <= 1'b0;
      latch <= 1'b0;
    end else begin
      sclk  <= ctl.sclk_nxt;
      latch <= ctl.latch_nxt;
      if (ctl.clear)
        sdata <= 1'b0;
      else if (ctl.load)
        sdata <= ctl.pad ? 1'b0 : rd_bit;
    end
  end
endmodule

// File: rtl/led_scan_rows.sv
module led_scan_rows #(
  parameter int NUM_PHASES = 16,
  localparam int PW = $clog2(NUM_PHASES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  blank_ev,
  input  logic                  show_ev,
  input  logic [PW-1:0]         phase,
  output logic [NUM_PHASES-1:0] row_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_en <= '0;
    end else if (blank_ev) begin
      row_en <= '0;
    end else if (show_ev) begin
      for (int i = 0; i < NUM_PHASES; i++)
        row_en[i] <= (PW'(i) == phase);
    end
  end
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int MAX_SCLK_HZ  = 3_300_000,
  parameter int HALF_DIV     = 16,
  parameter int NUM_CHAINS   = 2,
  parameter int CHAIN_BITS   = 192,
  parameter int PAD_BITS     = 8,
  parameter int NUM_PHASES   = 16,
  parameter int DEAD_CYCLES  = 25,
  parameter int LATCH_CYCLES = 200,
  localparam int IW = $clog2(CHAIN_BITS),
  localparam int PW = $clog2(NUM_PHASES)
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  fb_rd_en,
  output logic [PW+IW-1:0]      fb_addr,
  input  logic [NUM_CHAINS-1:0] fb_rd_data,
  output logic [NUM_CHAINS-1:0] sclk,
  output logic [NUM_CHAINS-1:0] sdata,
  output logic [NUM_CHAINS-1:0] latch,
  output logic [NUM_PHASES-1:0] row_en,
  output logic                  frame_start
);
  localparam int MIN_HALF = (CLK_HZ + 2 * MAX_SCLK_HZ - 1) / (2 * MAX_SCLK_HZ);
  localparam int HALF_EFF = (HALF_DIV > MIN_HALF) ? HALF_DIV : MIN_HALF;

  lane_ctl_t     ctl;
  logic          blank_ev, show_ev;
  logic [PW-1:0] phase;

  led_scan_seq #(
    .CHAIN_BITS  (CHAIN_BITS),
    .PAD_BITS    (PAD_BITS),
    .NUM_PHASES  (NUM_PHASES),
    .HALF        (HALF_EFF),
    .DEAD_CYCLES (DEAD_CYCLES),
    .LATCH_CYCLES(LATCH_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .rd_en      (fb_rd_en),
    .rd_addr    (fb_addr),
    .blank_ev   (blank_ev),
    .show_ev    (show_ev),
    .phase      (phase),
    .frame_start(frame_start)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_lane
    led_scan_lane u_lane (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl),
      .rd_bit(fb_rd_data[c]),
      .sclk  (sclk[c]),
      .sdata (sdata[c]),
      .latch (latch[c])
    );
  end

  led_scan_rows #(.NUM_PHASES(NUM_PHASES)) u_rows (
    .clk     (clk),
    .rst     (rst),
    .blank_ev(blank_ev),
    .show_ev (show_ev),
    .phase   (phase),
    .row_en  (row_en)
  );
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MAX_SCLK_HZ = 3_300_000,
  parameter int HALF_DIV    = 16,
  parameter int NUM_CHAINS  = 2,
  parameter int NUM_PHASES  = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_CHAINS-1:0] sclk,
  input logic [NUM_CHAINS-1:0] sdata,
  input logic [NUM_CHAINS-1:0] latch,
  input logic [NUM_PHASES-1:0] row_en,
  input logic                  frame_start
);
  localparam int MIN_HALF = (CLK_HZ + 2 * MAX_SCLK_HZ - 1) / (2 * MAX_SCLK_HZ);
  localparam int HALF_EFF = (HALF_DIV > MIN_HALF) ? HALF_DIV : MIN_HALF;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_ch
    logic [31:0] hi_run;
    always_ff @(posedge clk) begin
      if (rst) hi_run <= '0;
      else if (sclk[c]) hi_run <= hi_run + 32'd1;
      else hi_run <= '0;
    end

    p_sclk_half_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(sclk[c]) |-> (hi_run == 32'(HALF_EFF)));
    p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (sclk[c] && $past(sclk[c])) |-> $stable(sdata[c]));
    p_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
      (sclk[c] == sclk[0]) && (latch[c] == latch[0]));
    p_latch_no_clk_r6: assert property (@(posedge clk) disable iff (rst)
      latch[c] |-> !sclk[c]);
  end

  p_rows_dark_r9: assert property (@(posedge clk) disable iff (rst)
    latch[0] |-> (row_en == '0));
  p_rows_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_en));
  p_fs_single_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
endmodule

bind led_scan_ctrl led_scan_chk #(
  .CLK_HZ     (CLK_HZ),
  .MAX_SCLK_HZ(MAX_SCLK_HZ),
  .HALF_DIV   (HALF_DIV),
  .NUM_CHAINS (NUM_CHAINS),
  .NUM_PHASES (NUM_PHASES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sclk       (sclk),
  .sdata      (sdata),
  .latch      (latch),
  .row_en     (row_en),
  .frame_start(frame_start)
);

// File: tb/tb_led_scan_ctrl.sv
module tb_led_scan_ctrl;
  localparam int NC = 2, CB = 6, PAD = 2, NP = 16, DEAD = 2, LAT = 4;
  localparam int H = 3;                        // max(2, ceil(50M/20M))
  localparam int BT = 2 * H;
  localparam int TOT = CB + PAD;
  localparam int SH_END = 2 + TOT * BT;        // 50
  localparam int PER = SH_END + 2 * DEAD + LAT; // 58
  localparam int IW = 3, PW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic fb_rd_en, frame_start;
  logic [PW+IW-1:0] fb_addr;
  logic [NC-1:0] fb_rd_data, sclk, sdata, latch;
  logic [NP-1:0] row_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  led_scan_ctrl #(
    .CLK_HZ(50_000_000), .MAX_SCLK_HZ(10_000_000), .HALF_DIV(2),
    .NUM_CHAINS(NC), .CHAIN_BITS(CB), .PAD_BITS(PAD), .NUM_PHASES(NP),
    .DEAD_CYCLES(DEAD), .LATCH_CYCLES(LAT)
  ) dut (
    .clk(clk), .rst(rst), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr),
    .fb_rd_data(fb_rd_data), .sclk(sclk), .sdata(sdata), .latch(latch),
    .row_en(row_en), .frame_start(frame_start)
  );

  function automatic logic pix(int c, int p, int i);
    int v = p * 5 + i * 3 + c * 7 + p * i;
    return (v % 3) != 0;
  endfunction

  always @(posedge clk)
    if (fb_rd_en)
      for (int c = 0; c < NC; c++)
        fb_rd_data[c] <= pix(c, int'(fb_addr[PW+IW-1:IW]), int'(fb_addr[IW-1:0]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Independent per-cycle model of one row period (t = 0 is the first setup cycle).
  task automatic check_cycle(int p, int t, bit first);
    bit sh = (t >= 2) && (t < SH_END);
    int k = (t - 2) / BT;
    int h = (t - 2) % BT;
    logic [NC-1:0] e_sd;
    logic [31:0] e_rows;
    for (int c = 0; c < NC; c++)
      e_sd[c] = (sh && k >= PAD) ? pix(c, p, k - PAD) : 1'b0;
    e_rows = (t < SH_END && !first) ? (32'd1 << ((p + NP - 1) % NP)) : 32'd0;
    chk("R2 sclk", sclk, (sh && h >= H) ? 2'b11 : 2'b00);
    chk("R3/R4 sdata", sdata, e_sd);
    chk("R6 latch", latch, (t >= SH_END + DEAD && t < SH_END + DEAD + LAT) ? 2'b11 : 2'b00);
    chk("R7/R9 row_en", row_en, e_rows);
    chk("R8 frame_start", frame_start, (t == 0 && p == 0));
    if (sh && h == BT - 2 && k + 1 >= PAD && k + 1 < TOT) begin
      chk("R5 rd_en", fb_rd_en, 1);
      chk("R5 addr", fb_addr, (p << IW) | (k + 1 - PAD));
    end else begin
      chk("R5 rd_en idle", fb_rd_en, 0);
    end
  endtask

  task automatic check_quiet(string tag);
    chk({tag, " sclk"}, sclk, 0);
    chk({tag, " sdata"}, sdata, 0);
    chk({tag, " latch"}, latch, 0);
    chk({tag, " row_en"}, row_en, 0);
    chk({tag, " rd_en"}, fb_rd_en, 0);
  endtask

  // {offset in row period, sclk, latch, row_en value} for a phase-1 period
  localparam int NV = 12;
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 1}, '{2, 0, 0, 1}, '{5, 1, 0, 1}, '{8, 0, 0, 1},
    '{49, 1, 0, 1}, '{50, 0, 0, 0}, '{51, 0, 0, 0}, '{52, 0, 1, 0},
    '{55, 0, 1, 0}, '{56, 0, 0, 0}, '{57, 0, 0, 0}, '{58, 0, 0, 2}
  };

  initial begin
    int tcur;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after reset");
    // Full frame plus one wrap, every cycle
    for (int p = 0; p <= NP; p++)
      for (int t = 0; t < PER; t++) begin
        check_cycle(p % NP, t, p == 0);
        @(negedge clk);
      end
    // Vector table on phase 1
    tcur = 0;
    for (int v = 0; v < NV; v++) begin
      while (tcur < VEC[v][0]) begin
        @(negedge clk);
        tcur++;
      end
      chk("R2 table sclk", sclk, VEC[v][1] ? 2'b11 : 2'b00);
      chk("R6 table latch", latch, VEC[v][2] ? 2'b11 : 2'b00);
      chk("R7 table row_en", row_en, VEC[v][3]);
    end
    // Reset in the middle of a load
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_quiet("R1 mid reset");
    chk("R1 frame_start", frame_start, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int t = 0; t < PER; t++) begin
      check_cycle(0, t, 1'b1);
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule